// File: doc/BRIEF.md
# Banked General Register File with Exception Context Save

This block holds the sixteen architectural 32-bit general registers of a processor core together with the small set of control registers that decide how those registers are seen: the status word, its saved copy, the saved program counter, the saved stack pointer and the vector base. The lower eight architectural registers each exist twice in hardware. The status word decides which physical copy a register number refers to. The mode bit is bit 30 and the bank-select bit is bit 29. When the mode bit is 0, the first copy (bank 0) is always used. When the mode bit is 1, the bank-select bit picks the copy. Registers 8 to 15 have a single copy that every mode shares.

The block also owns the program counter register. An exception-entry strobe does the whole context save at one clock edge. It copies the program counter, the status word and register 15 into their saved registers. It sets the mode, bank-select and block bits. It loads the program counter with the vector base plus an offset supplied with the strobe. A handler therefore starts on the alternate register copy and does not need to save the interrupted code's low registers. A return strobe restores the status word and the program counter from their saved copies in one cycle.

Top module: `banked_regfile`

## Requirements
- R1: After synchronous reset, `pc_q` is 0xA000_0000 and `sr_q` is 0x7000_00F0, which means mode, bank-select and block bits set, interrupt mask 0xF and FPU-disable (bit 15) clear. `ssr_q`, `spc_q`, `sgr_q` and `vbr_q` are 0.
- R2: While `sr_q` bit 30 is 0, register numbers 0 to 7 address bank 0 for both reads and writes, whatever the value of bit 29.
- R3: While `sr_q` bit 30 is 1, register numbers 0 to 7 address bank 1 if bit 29 is 1 and bank 0 if bit 29 is 0. Each bank keeps its own contents.
- R4: Register numbers 8 to 15 have one physical copy that reads the same in every mode and bank setting, on both read ports.
- R5: Read data is registered and appears one clock after the index is presented. A write to the same register in that same cycle returns the previous contents.
- R6: A status write keeps only bits 0, 1, 4 to 9, 15 and 28 to 30, which is the mask 0x7000_83F3. All other status bits always read 0.
- R7: An exception-entry strobe copies the program counter to `spc_q`, the status word to `ssr_q` and register 15 to `sgr_q`. All three values are taken from before the edge.
- R8: An exception-entry strobe sets status bits 28, 29 and 30 and leaves all other status bits unchanged.
- R9: After an exception-entry strobe, `pc_q` equals `vbr_q` plus `exc_offset`, taken modulo 2^32.
- R10: A return strobe loads `sr_q` from `ssr_q` and `pc_q` from `spc_q` in one cycle.
- R11: If several controls are asserted in the same cycle, exception entry wins over return, and return wins over a status write or a program counter load.
- R12: If neither strobe is asserted, `pc_ld_en` loads `pc_ld_data` into `pc_q` and `vbr_wr_en` loads `vbr_wr_data` into `vbr_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Architectural register number, read port A |
| rd_a_data | output | 32 | Registered read data, port A |
| rd_b_idx | input | 4 | Architectural register number, read port B |
| rd_b_data | output | 32 | Registered read data, port B |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Architectural register number to write |
| wr_data | input | 32 | Write data |
| sr_wr_en | input | 1 | Status word write enable |
| sr_wr_data | input | 32 | Status word write value, masked |
| vbr_wr_en | input | 1 | Vector base write enable |
| vbr_wr_data | input | 32 | Vector base write value |
| pc_ld_en | input | 1 | Program counter load enable |
| pc_ld_data | input | 32 | Program counter load value |
| exc_enter | input | 1 | Exception-entry strobe |
| exc_offset | input | 32 | Vector offset added to the vector base on entry |
| exc_return | input | 1 | Return-from-exception strobe |
| sr_q | output | 32 | Status word |
| ssr_q | output | 32 | Saved status word |
| spc_q | output | 32 | Saved program counter |
| sgr_q | output | 32 | Saved register 15 |
| vbr_q | output | 32 | Vector base |
| pc_q | output | 32 | Program counter |

## Verification
The bench builds the block with its default parameters: 32-bit data, sixteen architectural registers and eight banked registers. With these values it can reach every bank-mapping case: user mode with the bank-select bit set, privileged mode on either bank, and the shared upper registers. The register 15 that feeds the saved stack pointer is a real architectural register at this size. The bench also drives both strobes together with a status write and a program counter load, which exposes the priority order.

// File: rtl/brf_pkg.sv
package brf_pkg;
  // status word bit positions that change behaviour
  localparam int SR_BL_BIT = 28;
  localparam int SR_RB_BIT = 29;
  localparam int SR_MD_BIT = 30;
  // implemented status bits: T, S, IMASK, Q, M, FD, BL, RB, MD
  localparam logic [31:0] SR_LIVE_MASK = 32'h7000_83F3;
  localparam logic [31:0] SR_RESET_VAL = 32'h7000_00F0;
  localparam logic [31:0] PC_RESET_VAL = 32'hA000_0000;
endpackage

// File: rtl/brf_bank_map.sv
module brf_bank_map #(
  parameter int NUM_ARCH   = 16,
  parameter int NUM_BANKED = 8,
  localparam int ARCH_W    = $clog2(NUM_ARCH),
  localparam int PHYS_N    = NUM_ARCH + NUM_BANKED,
  localparam int PHYS_W    = $clog2(PHYS_N)
) (
  input  logic [ARCH_W-1:0] arch_idx,
  input  logic              alt_bank,
  output logic [PHYS_W-1:0] phys_idx
);
  // layout: [0..NB-1] bank 0, [NB..2NB-1] bank 1, [2NB..] shared upper
  always_comb begin
    if (arch_idx < ARCH_W'(NUM_BANKED))
      phys_idx = alt_bank ? PHYS_W'(arch_idx) + PHYS_W'(NUM_BANKED)
                          : PHYS_W'(arch_idx);
    else
      phys_idx = PHYS_W'(arch_idx) + PHYS_W'(NUM_BANKED);
  end
endmodule

// File: rtl/brf_store.sv
module brf_store #(
  parameter int W     = 32,
  parameter int DEPTH = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  // synchronous read, read-before-write: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

  p_waddr_range_r4: assert property (@(posedge clk) we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/brf_ctrl.sv
module brf_ctrl
  import brf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sr_wr_en,
  input  logic [W-1:0] sr_wr_data,
  input  logic         vbr_wr_en,
  input  logic [W-1:0] vbr_wr_data,
  input  logic         pc_ld_en,
  input  logic [W-1:0] pc_ld_data,
  input  logic         exc_enter,
  input  logic [W-1:0] exc_offset,
  input  logic         exc_return,
  input  logic [W-1:0] sp_value,
  output logic [W-1:0] sr_q,
  output logic [W-1:0] ssr_q,
  output logic [W-1:0] spc_q,
  output logic [W-1:0] sgr_q,
  output logic [W-1:0] vbr_q,
  output logic [W-1:0] pc_q,
  output logic         alt_bank
);
  localparam logic [W-1:0] LIVE = W'(SR_LIVE_MASK);
  localparam logic [W-1:0] ENTRY_SET =
    (W'(1) << SR_MD_BIT) | (W'(1) << SR_RB_BIT) | (W'(1) << SR_BL_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= W'(SR_RESET_VAL);
      ssr_q <= '0;
      spc_q <= '0;
      sgr_q <= '0;
      vbr_q <= '0;
      pc_q  <= W'(PC_RESET_VAL);
    end else begin
      if (vbr_wr_en) vbr_q <= vbr_wr_data;
      if (exc_enter) begin
        ssr_q <= sr_q;
        spc_q <= pc_q;
        sgr_q <= sp_value;
        sr_q  <= sr_q | ENTRY_SET;
        pc_q  <= vbr_q + exc_offset;
      end else if (exc_return) begin
        sr_q  <= ssr_q & LIVE;
        pc_q  <= spc_q;
      end else begin
        if (sr_wr_en) sr_q <= sr_wr_data & LIVE;
        if (pc_ld_en) pc_q <= pc_ld_data;
      end
    end
  end

  assign alt_bank = sr_q[SR_MD_BIT] & sr_q[SR_RB_BIT];

  p_reset_vals_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (pc_q == W'(PC_RESET_VAL)) && (sr_q == W'(SR_RESET_VAL)));
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (sr_q & ~LIVE) == '0);
  p_entry_save_r7: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> (ssr_q == $past(sr_q)) && (spc_q == $past(pc_q)) && (sgr_q == $past(sp_value)));
  p_entry_bits_r8: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> sr_q[SR_MD_BIT] && sr_q[SR_RB_BIT] && sr_q[SR_BL_BIT]);
  p_vector_r9: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> pc_q == $past(vbr_q) + $past(exc_offset));
  p_return_r10: assert property (@(posedge clk) disable iff (rst)
    exc_return && !exc_enter |=> (sr_q == $past(ssr_q)) && (pc_q == $past(spc_q)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_ARCH   = 16,
  parameter int NUM_BANKED = 8,
  localparam int ARCH_W    = $clog2(NUM_ARCH),
  localparam int PHYS_N    = NUM_ARCH + NUM_BANKED,
  localparam int PHYS_W    = $clog2(PHYS_N),
  localparam int NPORT     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ARCH_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ARCH_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ARCH_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sr_wr_en,
  input  logic [DATA_W-1:0] sr_wr_data,
  input  logic              vbr_wr_en,
  input  logic [DATA_W-1:0] vbr_wr_data,
  input  logic              pc_ld_en,
  input  logic [DATA_W-1:0] pc_ld_data,
  input  logic              exc_enter,
  input  logic [DATA_W-1:0] exc_offset,
  input  logic              exc_return,
  output logic [DATA_W-1:0] sr_q,
  output logic [DATA_W-1:0] ssr_q,
  output logic [DATA_W-1:0] spc_q,
  output logic [DATA_W-1:0] sgr_q,
  output logic [DATA_W-1:0] vbr_q,
  output logic [DATA_W-1:0] pc_q
);
  localparam logic [ARCH_W-1:0] SP_IDX = ARCH_W'(NUM_ARCH - 1);

  logic              alt_bank;
  logic [DATA_W-1:0] sp_copy;
  logic [ARCH_W-1:0] arch_sel [NPORT];
  logic [PHYS_W-1:0] phys_sel [NPORT];

  assign arch_sel[0] = rd_a_idx;
  assign arch_sel[1] = rd_b_idx;
  assign arch_sel[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    brf_bank_map #(.NUM_ARCH(NUM_ARCH), .NUM_BANKED(NUM_BANKED)) u_map (
      .arch_idx (arch_sel[p]),
      .alt_bank (alt_bank),
      .phys_idx (phys_sel[p])
    );
  end

  brf_store #(.W(DATA_W), .DEPTH(PHYS_N)) u_store (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (phys_sel[2]),
    .wdata   (wr_data),
    .raddr_a (phys_sel[0]),
    .raddr_b (phys_sel[1]),
    .rdata_a (rd_a_data),
    .rdata_b (rd_b_data)
  );

  // flop copy of the stack pointer so the context save needs no third RAM port
  always_ff @(posedge clk) begin
    if (rst) sp_copy <= '0;
    else if (wr_en && wr_idx == SP_IDX) sp_copy <= wr_data;
  end

  brf_ctrl #(.W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sr_wr_en    (sr_wr_en),
    .sr_wr_data  (sr_wr_data),
    .vbr_wr_en   (vbr_wr_en),
    .vbr_wr_data (vbr_wr_data),
    .pc_ld_en    (pc_ld_en),
    .pc_ld_data  (pc_ld_data),
    .exc_enter   (exc_enter),
    .exc_offset  (exc_offset),
    .exc_return  (exc_return),
    .sp_value    (sp_copy),
    .sr_q        (sr_q),
    .ssr_q       (ssr_q),
    .spc_q       (spc_q),
    .sgr_q       (sgr_q),
    .vbr_q       (vbr_q),
    .pc_q        (pc_q),
    .alt_bank    (alt_bank)
  );

  p_user_bank0_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en && !sr_q[SR_MD_BIT] && (wr_idx < ARCH_W'(NUM_BANKED))
      |-> phys_sel[2] < PHYS_W'(NUM_BANKED));
  p_priv_bank1_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en && sr_q[SR_MD_BIT] && sr_q[SR_RB_BIT] && (wr_idx < ARCH_W'(NUM_BANKED))
      |-> (phys_sel[2] >= PHYS_W'(NUM_BANKED)) && (phys_sel[2] < PHYS_W'(2*NUM_BANKED)));
  p_sp_track_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_idx == SP_IDX |=> sp_copy == $past(wr_data));
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, sr_wr_en, vbr_wr_en, pc_ld_en, exc_enter, exc_return;
  logic [31:0] sr_wr_data, vbr_wr_data, pc_ld_data, exc_offset;
  logic [31:0] sr_q, ssr_q, spc_q, sgr_q, vbr_q, pc_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic [31:0] exp; } exp_t;
  exp_t sb_q[$];
  logic rd_req = 1'b0;
  logic req_seen = 1'b0;

  always #10 clk = ~clk;

  banked_regfile dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .vbr_wr_en(vbr_wr_en), .vbr_wr_data(vbr_wr_data),
    .pc_ld_en(pc_ld_en), .pc_ld_data(pc_ld_data),
    .exc_enter(exc_enter), .exc_offset(exc_offset), .exc_return(exc_return),
    .sr_q(sr_q), .ssr_q(ssr_q), .spc_q(spc_q), .sgr_q(sgr_q),
    .vbr_q(vbr_q), .pc_q(pc_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: a request seen at an edge has its data ready by the next falling edge
  always @(posedge clk) req_seen <= rd_req;
  always @(negedge clk) begin
    if (req_seen) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual=%h expected=none", rd_a_data);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, rd_a_data, e.exp);
      end
    end
  end

  // all tasks start just after a falling edge and end on the next one
  task automatic idle();
    @(negedge clk);
  endtask

  task automatic gpr_wr(input logic [3:0] idx, input logic [31:0] val);
    wr_en = 1'b1; wr_idx = idx; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    exp_t e;
    e.tag = tag; e.exp = exp;
    sb_q.push_back(e);
    rd_a_idx = idx; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic sr_wr(input logic [31:0] val);
    sr_wr_en = 1'b1; sr_wr_data = val;
    @(negedge clk);
    sr_wr_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0; wr_en = 1'b0;
    sr_wr_en = 1'b0; sr_wr_data = '0; vbr_wr_en = 1'b0; vbr_wr_data = '0;
    pc_ld_en = 1'b0; pc_ld_data = '0; exc_enter = 1'b0; exc_offset = '0; exc_return = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 pc reset", pc_q, 32'hA000_0000);
    chk("R1 sr reset", sr_q, 32'h7000_00F0);
    chk("R1 ssr reset", ssr_q, 32'h0);
    chk("R1 spc reset", spc_q, 32'h0);
    chk("R1 sgr reset", sgr_q, 32'h0);
    chk("R1 vbr reset", vbr_q, 32'h0);

    // fill bank 0 and the upper registers in privileged mode, bank-select 0
    sr_wr(32'h4000_0000);
    for (int i = 0; i < 16; i++) gpr_wr(4'(i), (i < 8) ? 32'h100 + i : 32'h200 + i);
    // fill bank 1
    sr_wr(32'h6000_0000);
    for (int i = 0; i < 8; i++) gpr_wr(4'(i), 32'h300 + i);

    rd_expect(4'd3, 32'h303, "R3 priv bank1 r3");
    rd_expect(4'd12, 32'h20C, "R4 upper shared in bank1 view");
    sr_wr(32'h4000_0000);
    rd_expect(4'd3, 32'h103, "R3 priv bank0 r3");
    // user mode with bank-select set: still bank 0
    sr_wr(32'h2000_0000);
    rd_expect(4'd3, 32'h103, "R2 user ignores bank-select");
    gpr_wr(4'd5, 32'hAAAA);
    rd_expect(4'd5, 32'hAAAA, "R2 user write lands in bank0");
    sr_wr(32'h6000_0000);
    rd_expect(4'd5, 32'h305, "R2 bank1 untouched by user write");
    rd_expect(4'd12, 32'h20C, "R4 upper shared in user view");
    rd_b_idx = 4'd8;
    @(negedge clk);
    chk("R4 port B upper reg", rd_b_data, 32'h208);

    // read-before-write on the same register
    wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'hBEEF;
    rd_expect(4'd9, 32'h209, "R5 same-cycle read sees old");
    wr_en = 1'b0;
    rd_expect(4'd9, 32'hBEEF, "R5 next read sees new");

    sr_wr(32'hFFFF_FFFF);
    chk("R6 status mask", sr_q, 32'h7000_83F3);
    sr_wr(32'h0000_0011);
    chk("R6 status plain write", sr_q, 32'h0000_0011);

    pc_ld_en = 1'b1; pc_ld_data = 32'h0000_1234;
    vbr_wr_en = 1'b1; vbr_wr_data = 32'h8C00_0000;
    @(negedge clk);
    pc_ld_en = 1'b0; vbr_wr_en = 1'b0;
    chk("R12 pc load", pc_q, 32'h0000_1234);
    chk("R12 vbr load", vbr_q, 32'h8C00_0000);

    exc_enter = 1'b1; exc_offset = 32'h600;
    @(negedge clk);
    exc_enter = 1'b0;
    chk("R7 ssr saved", ssr_q, 32'h0000_0011);
    chk("R7 spc saved", spc_q, 32'h0000_1234);
    chk("R7 sgr saved R15", sgr_q, 32'h20F);
    chk("R8 entry bits", sr_q, 32'h7000_0011);
    chk("R9 vector pc", pc_q, 32'h8C00_0600);
    rd_expect(4'd0, 32'h300, "R3 handler sees bank1");

    exc_return = 1'b1;
    @(negedge clk);
    exc_return = 1'b0;
    chk("R10 sr restored", sr_q, 32'h0000_0011);
    chk("R10 pc restored", pc_q, 32'h0000_1234);
    rd_expect(4'd0, 32'h100, "R2 back on bank0 after return");

    // all controls together: entry wins
    exc_enter = 1'b1; exc_return = 1'b1; exc_offset = 32'h100;
    sr_wr_en = 1'b1; sr_wr_data = 32'hFFFF_FFFF; pc_ld_en = 1'b1; pc_ld_data = 32'h9999;
    @(negedge clk);
    exc_enter = 1'b0;
    chk("R11 entry beats rest sr", sr_q, 32'h7000_0011);
    chk("R11 entry beats rest pc", pc_q, 32'h8C00_0100);
    chk("R11 entry beats rest spc", spc_q, 32'h0000_1234);
    // return still with status write and pc load: return wins
    @(negedge clk);
    exc_return = 1'b0; sr_wr_en = 1'b0; pc_ld_en = 1'b0;
    chk("R11 return beats write sr", sr_q, 32'h0000_0011);
    chk("R11 return beats load pc", pc_q, 32'h0000_1234);

    idle();
    idle();
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule